// File: doc/BRIEF.md
# Serial Peripheral Slave with Status Prefix

This block is the serial-side front end of a peripheral that a master controller talks to over a four-wire synchronous serial link. When the active-low select goes low, the block clears its transfer state. It also captures two status bytes from its input ports. Those two bytes are the first data the master clocks out of the slave, so the master sees the peripheral's event status before any command response. The local host supplies any further response bytes through a small write queue. Every complete byte the master sends comes out on a parallel port with a one-cycle valid strobe.

The serial clock, data-in and select pins are brought into the system clock domain through two-flop synchronisers. All edges are detected in that domain, so the system clock must run well above the serial clock. The parameters `CPOL` and `CPHA` choose the clock polarity and phase, and the block behaves the same in every combination. Raising select ends the transfer. A partly received byte is then dropped and a one-cycle end pulse is issued.

The control state machine has three states. In `ST_IDLE` select is high. In `ST_SHIFT` a transfer is running. `ST_DONE` lasts one cycle and raises the end pulse. The transitions are as follows:
- `ST_IDLE` goes to `ST_SHIFT` on a select fall.
- `ST_SHIFT` goes to `ST_DONE` on a select rise.
- `ST_DONE` goes back to `ST_IDLE`, or to `ST_SHIFT` if select has fallen again.

Top module: `spi_status_slave`

## Requirements
- R1: After reset, `miso`, `rx_valid`, `xfer_end`, `underrun` and `tx_full` are all 0.
- R2: The values of `sys_evt` and `gen_evt` are captured at each select fall. The first byte shifted out is the captured `sys_evt` and the second is the captured `gen_evt`. Changes on those inputs later in the transfer have no effect on them.
- R3: After the two status bytes, bytes written with `tx_we` are shifted out in write order, most significant bit first.
- R4: If the queue is empty when a response byte is due, 0x00 is shifted out. `underrun` is set when that filler byte's first bit is sampled. It stays at 1 until the next select fall clears it.
- R5: Each complete byte received on `mosi` (most significant bit first) appears on `rx_data`, with `rx_valid` high for exactly one clock.
- R6: Bytes sent back to back and bytes separated by any idle pause give identical results.
- R7: A select rise produces a one-clock `xfer_end` pulse. A partial byte received before it gives no `rx_valid`.
- R8: `tx_full` is 1 when the queue holds `QDEPTH` bytes. A write made while it is full is dropped.
- R9: A select fall empties the response queue. Bytes left over from an earlier transfer are never sent.
- R10: `miso` is 0 whenever no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| sys_evt | input | DW | First status byte, captured at select fall |
| gen_evt | input | DW | Second status byte, captured at select fall |
| tx_data | input | DW | Response byte to queue |
| tx_we | input | 1 | Write strobe for `tx_data` |
| tx_full | output | 1 | Response queue full |
| rx_data | output | DW | Last complete received byte |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| xfer_end | output | 1 | One-clock pulse after select rises |
| underrun | output | 1 | Sticky flag: a filler byte was sent in this transfer |

## Verification
The main path is driven from a table of transfers that vary the two status values, the queued response and the data-in pattern. The data-in patterns are all zeros, all ones, alternating bits and mixed bits, so a stuck, inverted or reordered bit shows up on either data line. Some rows put a pause between bytes and some run the bytes back to back, which separates real edge counting from any dependence on timing. Directed cases then cover changing the status inputs mid-transfer, an empty queue, a full queue with an extra write, a byte cut short by select, and bytes left in the queue across a new select fall.

// File: rtl/spi_status_pkg.sv
package spi_status_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DONE
    } xfer_state_t;

    // Index of the next byte source to load into the shift register.
    localparam logic [1:0] SRC_SYS   = 2'd0;
    localparam logic [1:0] SRC_GEN   = 2'd1;
    localparam logic [1:0] SRC_QUEUE = 2'd2;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/resp_queue.sv
module resp_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end
endmodule

// File: rtl/spi_status_slave.sv
module spi_status_slave
    import spi_status_pkg::*;
#(
    parameter int DW     = 8,
    parameter int QDEPTH = 4,
    parameter bit CPOL   = 1'b0,
    parameter bit CPHA   = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          ss_n,
    input  logic          mosi,
    output logic          miso,
    input  logic [DW-1:0] sys_evt,
    input  logic [DW-1:0] gen_evt,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_we,
    output logic          tx_full,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          xfer_end,
    output logic          underrun
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    xfer_state_t state, nstate;

    logic          ss_s, sclk_s, mosi_s, ss_d, sclk_d;
    logic          ss_fall, ss_rise, lead_e, trail_e, sample_e, shift_e;
    logic [BW-1:0] bitcnt;
    logic [DW-1:0] txsh, rxsh, st_sys, st_gen, q_rdata;
    logic [1:0]    src_idx;
    logic          filler, q_empty, q_rd;

    pin_sync #(.W(3), .RST_VAL({1'b1, CPOL, 1'b0})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n, sclk, mosi}),
        .q     ({ss_s, sclk_s, mosi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_d   <= 1'b1;
            sclk_d <= CPOL;
        end else begin
            ss_d   <= ss_s;
            sclk_d <= sclk_s;
        end
    end

    assign ss_fall = ss_d && !ss_s;
    assign ss_rise = !ss_d && ss_s;
    assign lead_e  = (sclk_s != sclk_d) && (sclk_d == CPOL);
    assign trail_e = (sclk_s != sclk_d) && (sclk_d != CPOL);

    generate
        if (CPHA) begin : g_phase1
            assign shift_e  = (state == ST_SHIFT) && lead_e;
            assign sample_e = (state == ST_SHIFT) && trail_e;
        end else begin : g_phase0
            assign sample_e = (state == ST_SHIFT) && lead_e;
            assign shift_e  = (state == ST_SHIFT) && trail_e;
        end
    endgenerate

    assign q_rd = shift_e && (bitcnt == '0) && (src_idx == SRC_QUEUE) && !q_empty;

    resp_queue #(.DW(DW), .DEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ss_fall),
        .wr    (tx_we),
        .wdata (tx_data),
        .rd    (q_rd),
        .rdata (q_rdata),
        .empty (q_empty),
        .full  (tx_full)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (ss_fall) nstate = ST_SHIFT;
            ST_SHIFT: if (ss_rise) nstate = ST_DONE;
            ST_DONE:  nstate = ss_fall ? ST_SHIFT : ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        xfer_end = 1'b0;
        miso     = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SHIFT: miso = txsh[DW-1];
            ST_DONE:  xfer_end = 1'b1;
            default:  ;
        endcase
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            txsh     <= '0;
            rxsh     <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            st_sys   <= '0;
            st_gen   <= '0;
            src_idx  <= SRC_SYS;
            filler   <= 1'b0;
            underrun <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (ss_fall) begin
                st_sys   <= sys_evt;
                st_gen   <= gen_evt;
                bitcnt   <= '0;
                rxsh     <= '0;
                filler   <= 1'b0;
                underrun <= 1'b0;
                if (CPHA) begin
                    txsh    <= '0;
                    src_idx <= SRC_SYS;
                end else begin
                    txsh    <= sys_evt;
                    src_idx <= SRC_GEN;
                end
            end else begin
                if (sample_e) begin
                    rxsh   <= {rxsh[DW-2:0], mosi_s};
                    bitcnt <= (bitcnt == LAST_BIT) ? '0 : bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) begin
                        rx_data  <= {rxsh[DW-2:0], mosi_s};
                        rx_valid <= 1'b1;
                    end
                    if (bitcnt == '0 && filler) underrun <= 1'b1;
                end
                if (shift_e) begin
                    if (bitcnt == '0) begin
                        unique case (src_idx)
                            SRC_SYS: begin
                                txsh    <= st_sys;
                                filler  <= 1'b0;
                                src_idx <= SRC_GEN;
                            end
                            SRC_GEN: begin
                                txsh    <= st_gen;
                                filler  <= 1'b0;
                                src_idx <= SRC_QUEUE;
                            end
                            default: begin
                                txsh   <= q_empty ? '0 : q_rdata;
                                filler <= q_empty;
                            end
                        endcase
                    end else begin
                        txsh <= {txsh[DW-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_status_slave_chk.sv
module spi_status_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic idle,
    input logic miso,
    input logic rx_valid,
    input logic xfer_end,
    input logic underrun,
    input logic ss_fall,
    input logic tx_full,
    input logic tx_we,
    input logic q_rd
);
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r7_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> !xfer_end);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !miso);

    a_r4_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !ss_fall) |=> underrun);

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> !tx_full);

    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_we && !q_rd && !ss_fall) |=> tx_full);
endmodule

bind spi_status_slave spi_status_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (state == ST_IDLE),
    .miso     (miso),
    .rx_valid (rx_valid),
    .xfer_end (xfer_end),
    .underrun (underrun),
    .ss_fall  (ss_fall),
    .tx_full  (tx_full),
    .tx_we    (tx_we),
    .q_rd     (q_rd)
);

// File: tb/tb_spi_status_slave.sv
module tb_spi_status_slave;
    localparam int DW = 8;
    localparam int QDEPTH = 4;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic [DW-1:0] sys_evt = '0, gen_evt = '0, tx_data = '0;
    logic tx_we = 1'b0;
    logic miso, tx_full, rx_valid, xfer_end, underrun;
    logic [DW-1:0] rx_data;

    int n_chk = 0, n_err = 0, rx_n = 0, end_n = 0;
    logic [DW-1:0] rx_log [64];
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_status_slave #(.DW(DW), .QDEPTH(QDEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .sys_evt(sys_evt), .gen_evt(gen_evt), .tx_data(tx_data),
        .tx_we(tx_we), .tx_full(tx_full), .rx_data(rx_data), .rx_valid(rx_valid),
        .xfer_end(xfer_end), .underrun(underrun)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_log[rx_n % 64] <= rx_data;
            rx_n <= rx_n + 1;
        end
        if (xfer_end) end_n <= end_n + 1;
    end

    // row: sys, gen, resp, mosi pattern, pause cycles
    localparam logic [39:0] VEC [4] = '{
        {8'hA5, 8'h3C, 8'h81, 8'h00, 8'd0},
        {8'h01, 8'h80, 8'h7E, 8'hFF, 8'd25},
        {8'hFF, 8'h00, 8'h55, 8'hAA, 8'd0},
        {8'h5A, 8'hC3, 8'h0F, 8'h96, 8'd40}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sel_low();
        @(negedge clk) ss_n = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic sel_high();
        repeat (6) @(negedge clk);
        ss_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic host_write(input logic [DW-1:0] d);
        @(negedge clk);
        tx_data = d;
        tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic xbits(input logic [DW-1:0] mo, input int nbits, output logic [DW-1:0] mi);
        mi = '0;
        for (int i = DW - 1; i >= DW - nbits; i--) begin
            @(negedge clk) mosi = mo[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            mi[i] = miso;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [DW-1:0] mo, output logic [DW-1:0] mi);
        xbits(mo, DW, mi);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] mi, m0, m1, m2;
        int base, e0;
        repeat (3) @(negedge clk);
        // R1 / R10: reset state
        chk(miso == 0 && rx_valid == 0 && xfer_end == 0, "R1 outputs", {miso, rx_valid, xfer_end}, 0);
        chk(underrun == 0 && tx_full == 0, "R1 flags", {underrun, tx_full}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(miso == 0, "R10 idle miso", miso, 0);

        // Table walk: R2 R3 R5 R6 R7
        for (int r = 0; r < 4; r++) begin
            sys_evt = VEC[r][39:32];
            gen_evt = VEC[r][31:24];
            m0 = VEC[r][15:8];
            m1 = ~m0;
            m2 = m0 ^ 8'h5A;
            base = rx_n;
            e0 = end_n;
            sel_low();
            host_write(VEC[r][23:16]);
            xbyte(m0, mi);
            chk(mi == VEC[r][39:32], "R2 first status", mi, VEC[r][39:32]);
            repeat (VEC[r][7:0]) @(negedge clk);
            xbyte(m1, mi);
            chk(mi == VEC[r][31:24], "R2 second status", mi, VEC[r][31:24]);
            repeat (VEC[r][7:0]) @(negedge clk);
            xbyte(m2, mi);
            chk(mi == VEC[r][23:16], "R3 response byte", mi, VEC[r][23:16]);
            sel_high();
            chk(rx_n - base == 3, "R6 rx byte count", rx_n - base, 3);
            chk(rx_log[base % 64] == m0, "R5 rx byte 0", rx_log[base % 64], m0);
            chk(rx_log[(base + 1) % 64] == m1, "R5 rx byte 1", rx_log[(base + 1) % 64], m1);
            chk(rx_log[(base + 2) % 64] == m2, "R5 rx byte 2", rx_log[(base + 2) % 64], m2);
            chk(end_n - e0 == 1, "R7 end pulse", end_n - e0, 1);
            chk(miso == 0, "R10 miso after end", miso, 0);
        end

        // R2: status inputs changing mid-transfer are ignored
        sys_evt = 8'h12;
        gen_evt = 8'h34;
        sel_low();
        sys_evt = 8'hEE;
        gen_evt = 8'hDD;
        xbyte(8'h00, mi);
        chk(mi == 8'h12, "R2 captured sys", mi, 8'h12);
        xbyte(8'h00, mi);
        chk(mi == 8'h34, "R2 captured gen", mi, 8'h34);
        // R4: empty queue gives filler and underrun
        chk(underrun == 0, "R4 no underrun yet", underrun, 0);
        xbyte(8'h00, mi);
        chk(mi == 8'h00, "R4 filler byte", mi, 0);
        chk(underrun == 1, "R4 underrun set", underrun, 1);
        sel_high();
        chk(underrun == 1, "R4 underrun sticky", underrun, 1);
        sel_low();
        chk(underrun == 0, "R4 underrun cleared", underrun, 0);

        // R8 / R3: fill queue, extra write dropped, write order kept
        for (int k = 0; k < QDEPTH; k++) host_write(DW'(8'hC0 + k));
        chk(tx_full == 1, "R8 full flag", tx_full, 1);
        host_write(8'h99);
        chk(tx_full == 1, "R8 still full", tx_full, 1);
        xbyte(8'h00, mi);
        xbyte(8'h00, mi);
        for (int k = 0; k < QDEPTH; k++) begin
            xbyte(8'h00, mi);
            chk(mi == DW'(8'hC0 + k), "R3 queue order", mi, 8'hC0 + k);
        end
        xbyte(8'h00, mi);
        chk(mi == 8'h00, "R8 extra write dropped", mi, 0);
        sel_high();

        // R7: partial byte discarded
        base = rx_n;
        e0 = end_n;
        sel_low();
        xbits(8'hF0, 4, mi);
        sel_high();
        chk(rx_n == base, "R7 partial byte dropped", rx_n - base, 0);
        chk(end_n - e0 == 1, "R7 end after partial", end_n - e0, 1);

        // R9: leftover queued bytes flushed at next select fall
        sys_evt = 8'h11;
        gen_evt = 8'h22;
        sel_low();
        host_write(8'h6B);
        host_write(8'h6C);
        xbyte(8'h00, mi);
        sel_high();
        sel_low();
        xbyte(8'h00, mi);
        xbyte(8'h00, mi);
        xbyte(8'h00, mi);
        chk(mi == 8'h00, "R9 queue flushed", mi, 0);
        sel_high();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule